// File: doc/BRIEF.md
# I2C Target Address Matcher

This block sits behind an I2C line conditioner and decides whether the current bus transaction is addressed to this target. The conditioner delivers a one-clock start pulse and two one-clock clock-edge strobes: one on each rise of the serial clock, and one a little after each fall. After every start the matcher takes one data-line sample per rising strobe. The first seven samples are the address, most significant bit first. The eighth sample is the direction bit.

Each address sample is checked against a stored seven-bit own address as soon as it arrives. A wrong sample flags failure at once, and the block then stays passive until the next start. When all seven samples agree, the block enables its data-line pull-down for the acknowledge period. That period opens on the delayed falling strobe after the direction bit and closes on the next delayed falling strobe. When it closes, the block reports success and holds the direction bit. Handling the data bytes that follow the address is left to other logic.

Top module: `i2c_addr_matcher`

## Requirements
- R1: While reset is asserted and right after it is released, `ack_drive`, `rw_flag`, `match_ok` and `match_bad` are all 0.
- R2: `own_addr_q` follows `own_addr_in` in every cycle where `own_addr_load` is 1. When `own_addr_load` is 0 it holds its value, so later changes on `own_addr_in` have no effect on which address matches.
- R3: A `start_pulse` clears `match_ok`, `match_bad`, `rw_flag` and `ack_drive` by the next cycle and begins a new address phase. If a strobe arrives in the same cycle as the start, the start wins.
- R4: Address samples are taken from `sda_in` on `scl_rise` strobes only. The k-th sample after a start (k = 0..6) is compared with own address bit 6-k, so the most significant bit comes first.
- R5: In the cycle after the first rising strobe whose sample differs from the stored bit, `match_bad` goes to 1. It stays 1 until the next start, and `match_ok` stays 0 for that frame.
- R6: The eighth rising strobe after a start, in a frame with no mismatch, loads `rw_flag` with the sampled value. 1 means read and 0 means write.
- R7: In a fully matching frame, `ack_drive` goes to 1 on the first `scl_fall_dly` after the direction sample, and not before. It returns to 0 on the following `scl_fall_dly`.
- R8: The `scl_fall_dly` that ends the acknowledge period sets `match_ok` to 1 while `match_bad` stays 0. Both then hold until the next start.
- R9: In a failed frame `ack_drive` is never 1, and further strobes, including the one carrying the direction bit, leave every output unchanged.
- R10: `match_ok`, `match_bad`, `rw_flag` and `ack_drive` change only in cycles that carry `start_pulse`, `scl_rise` or `scl_fall_dly`. Strobes that arrive after a frame has finished are ignored.
- R11: A start that arrives partway through a frame resets the bit position to zero, so the next sample is treated as the most significant address bit again.
- R12: Strobes that arrive after reset but before the first start have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr_load | input | 1 | Capture enable for the own address |
| own_addr_in | input | 7 | Own address value to capture |
| start_pulse | input | 1 | One-cycle start condition indication |
| scl_rise | input | 1 | One-cycle strobe on each serial clock rise |
| scl_fall_dly | input | 1 | One-cycle strobe shortly after each serial clock fall |
| sda_in | input | 1 | Conditioned data line level |
| ack_drive | output | 1 | Data-line pull-down enable during acknowledge |
| rw_flag | output | 1 | Direction bit of the matched frame, 1 = read |
| match_ok | output | 1 | Frame addressed this target, acknowledge done |
| match_bad | output | 1 | Frame carried a different address |

## Verification
The assertions assume that the strobes and the start pulse are each one cycle wide. They also assume that a falling strobe always sits between two rising strobes, so that the "first falling strobe after the direction bit" is well defined. The bench drives every input on the falling clock edge, keeps each pulse exactly one cycle long, and inserts idle cycles between each rising strobe and the falling strobe that follows it. It also checks outputs during those idle cycles. The one deliberate departure is a start placed in the middle of a frame. That case stays inside the assumptions, because a start is allowed at any strobe boundary.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  // Default own-address width for the matcher family.
  localparam int unsigned DEF_ADDR_W = 7;

  // Phase of the address transfer as seen by the target.
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,  // no start seen since reset
    PH_ADDR   = 3'd1,  // collecting address and direction samples
    PH_RW_END = 3'd2,  // direction sampled, waiting for its period to end
    PH_ACK    = 3'd3,  // acknowledge period, pull-down enabled
    PH_DONE   = 3'd4,  // frame matched and acknowledged
    PH_MUTE   = 3'd5   // frame mismatched, passive until next start
  } phase_e;

endpackage

// File: rtl/i2c_tgt_own_addr.sv
module i2c_tgt_own_addr #(
  parameter int unsigned ADDR_W = i2c_tgt_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= addr_in;
    end
  end

endmodule

// File: rtl/i2c_tgt_bit_cmp.sv
module i2c_tgt_bit_cmp #(
  parameter int unsigned ADDR_W = i2c_tgt_pkg::DEF_ADDR_W,
  parameter int unsigned CNT_W  = $clog2(ADDR_W + 1)
) (
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic              sda,
  input  logic              addr_bit_evt,
  output logic              bit_miss
);

  // Expected level of the sample at position idx (position 0 = MSB).
  function automatic logic expect_bit(input logic [ADDR_W-1:0] a,
                                      input logic [CNT_W-1:0]  idx);
    logic r;
    r = 1'b0;
    for (int unsigned p = 0; p < ADDR_W; p++) begin
      if (int'(idx) == int'(p)) r = a[ADDR_W-1-p];
    end
    return r;
  endfunction

  logic want;

  always_comb begin
    want     = expect_bit(own_addr, bit_idx);
    bit_miss = addr_bit_evt && (sda != want);
  end

endmodule

// File: rtl/i2c_tgt_seq.sv
module i2c_tgt_seq
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned CNT_W  = $clog2(ADDR_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             bit_miss,
  output logic [CNT_W-1:0] bit_idx,
  output logic             addr_bit_evt,
  output logic             rw_bit_evt,
  output logic             ack_open_evt,
  output logic             ack_close_evt
);

  localparam logic [CNT_W-1:0] RW_IDX = CNT_W'(ADDR_W);

  phase_e phase_q, phase_d;
  logic [CNT_W-1:0] idx_d;

  // A start cancels any strobe that shares its cycle.
  always_comb begin
    addr_bit_evt  = !start && scl_rise && (phase_q == PH_ADDR) && (bit_idx < RW_IDX);
    rw_bit_evt    = !start && scl_rise && (phase_q == PH_ADDR) && (bit_idx == RW_IDX);
    ack_open_evt  = !start && scl_fall && (phase_q == PH_RW_END);
    ack_close_evt = !start && scl_fall && (phase_q == PH_ACK);
  end

  always_comb begin
    phase_d = phase_q;
    idx_d   = bit_idx;
    if (start) begin
      phase_d = PH_ADDR;
      idx_d   = '0;
    end else if (addr_bit_evt) begin
      idx_d = bit_idx + 1'b1;
      if (bit_miss) phase_d = PH_MUTE;
    end else if (rw_bit_evt) begin
      phase_d = PH_RW_END;
    end else if (ack_open_evt) begin
      phase_d = PH_ACK;
    end else if (ack_close_evt) begin
      phase_d = PH_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_idx <= '0;
    end else begin
      phase_q <= phase_d;
      bit_idx <= idx_d;
    end
  end

endmodule

// File: rtl/i2c_tgt_result.sv
module i2c_tgt_result (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sda,
  input  logic bit_miss,
  input  logic rw_bit_evt,
  input  logic ack_open_evt,
  input  logic ack_close_evt,
  output logic ack_drive,
  output logic rw_flag,
  output logic match_ok,
  output logic match_bad
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_drive <= 1'b0;
      rw_flag   <= 1'b0;
      match_ok  <= 1'b0;
      match_bad <= 1'b0;
    end else if (start) begin
      ack_drive <= 1'b0;
      rw_flag   <= 1'b0;
      match_ok  <= 1'b0;
      match_bad <= 1'b0;
    end else begin
      if (bit_miss)      match_bad <= 1'b1;
      if (rw_bit_evt)    rw_flag   <= sda;
      if (ack_open_evt)  ack_drive <= 1'b1;
      if (ack_close_evt) begin
        ack_drive <= 1'b0;
        match_ok  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher #(
  parameter int unsigned ADDR_W = i2c_tgt_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own_addr_load,
  input  logic [ADDR_W-1:0] own_addr_in,
  input  logic              start_pulse,
  input  logic              scl_rise,
  input  logic              scl_fall_dly,
  input  logic              sda_in,
  output logic              ack_drive,
  output logic              rw_flag,
  output logic              match_ok,
  output logic              match_bad
);

  localparam int unsigned CNT_W = $clog2(ADDR_W + 1);

  logic [ADDR_W-1:0] own_addr_q;
  logic [CNT_W-1:0]  bit_idx;
  logic              addr_bit_evt;
  logic              rw_bit_evt;
  logic              ack_open_evt;
  logic              ack_close_evt;
  logic              bit_miss_evt;

  i2c_tgt_own_addr #(.ADDR_W(ADDR_W)) u_own (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (own_addr_load),
    .addr_in (own_addr_in),
    .addr_q  (own_addr_q)
  );

  i2c_tgt_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start_pulse),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall_dly),
    .bit_miss      (bit_miss_evt),
    .bit_idx       (bit_idx),
    .addr_bit_evt  (addr_bit_evt),
    .rw_bit_evt    (rw_bit_evt),
    .ack_open_evt  (ack_open_evt),
    .ack_close_evt (ack_close_evt)
  );

  i2c_tgt_bit_cmp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cmp (
    .own_addr     (own_addr_q),
    .bit_idx      (bit_idx),
    .sda          (sda_in),
    .addr_bit_evt (addr_bit_evt),
    .bit_miss     (bit_miss_evt)
  );

  i2c_tgt_result u_res (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start_pulse),
    .sda           (sda_in),
    .bit_miss      (bit_miss_evt),
    .rw_bit_evt    (rw_bit_evt),
    .ack_open_evt  (ack_open_evt),
    .ack_close_evt (ack_close_evt),
    .ack_drive     (ack_drive),
    .rw_flag       (rw_flag),
    .match_ok      (match_ok),
    .match_bad     (match_bad)
  );

endmodule

// File: rtl/i2c_addr_matcher_chk.sv
module i2c_addr_matcher_chk (
  input logic clk,
  input logic rst_n,
  input logic start_pulse,
  input logic scl_rise,
  input logic scl_fall_dly,
  input logic ack_drive,
  input logic rw_flag,
  input logic match_ok,
  input logic match_bad,
  input logic bit_miss_evt,
  input logic ack_close_evt
);

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (!match_ok && !match_bad && !ack_drive && !rw_flag));

  assert_miss_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_miss_evt |=> match_bad);

  assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_bad && !start_pulse) |=> match_bad);

  assert_drive_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drive) |-> $past(scl_fall_dly));

  assert_close_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_close_evt |=> (!ack_drive && match_ok));

  assert_ok_at_ack_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_ok) |-> ($fell(ack_drive) && !match_bad));

  assert_ok_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ok && !start_pulse) |=> match_ok);

  assert_fail_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_bad |-> (!match_ok && !ack_drive));

  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_pulse && !scl_rise && !scl_fall_dly) |=>
      ($stable(match_ok) && $stable(match_bad) && $stable(rw_flag) && $stable(ack_drive)));

endmodule

bind i2c_addr_matcher i2c_addr_matcher_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_pulse   (start_pulse),
  .scl_rise      (scl_rise),
  .scl_fall_dly  (scl_fall_dly),
  .ack_drive     (ack_drive),
  .rw_flag       (rw_flag),
  .match_ok      (match_ok),
  .match_bad     (match_bad),
  .bit_miss_evt  (bit_miss_evt),
  .ack_close_evt (ack_close_evt)
);

// File: tb/test_i2c_addr_matcher.sv
module test_i2c_addr_matcher;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WATCHDOG = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       own_addr_load = 1'b0;
  logic [6:0] own_addr_in = '0;
  logic       start_pulse = 1'b0;
  logic       scl_rise = 1'b0;
  logic       scl_fall_dly = 1'b0;
  logic       sda_in = 1'b1;
  logic       ack_drive, rw_flag, match_ok, match_bad;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_addr_matcher i_i2c_addr_matcher (
    .clk(clk), .rst_n(rst_n), .own_addr_load(own_addr_load), .own_addr_in(own_addr_in),
    .start_pulse(start_pulse), .scl_rise(scl_rise), .scl_fall_dly(scl_fall_dly),
    .sda_in(sda_in), .ack_drive(ack_drive), .rw_flag(rw_flag),
    .match_ok(match_ok), .match_bad(match_bad)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Check all four outputs against expected values.
  task automatic chk_all(string req, logic e_ok, logic e_bad, logic e_rw, logic e_drv);
    chk(req, "match_ok", match_ok, e_ok);
    chk(req, "match_bad", match_bad, e_bad);
    chk(req, "rw_flag", rw_flag, e_rw);
    chk(req, "ack_drive", ack_drive, e_drv);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_own(logic [6:0] a);
    @(negedge clk); own_addr_load = 1'b1; own_addr_in = a;
    @(negedge clk); own_addr_load = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start_pulse = 1'b1;
    @(negedge clk); start_pulse = 1'b0;
  endtask

  task automatic rise(logic b);
    @(negedge clk); sda_in = b; scl_rise = 1'b1;
    @(negedge clk); scl_rise = 1'b0;
  endtask

  task automatic fall();
    @(negedge clk); scl_fall_dly = 1'b1;
    @(negedge clk); scl_fall_dly = 1'b0;
  endtask

  task automatic send_bit(logic b);
    rise(b);
    idle(1);
    fall();
  endtask

  // Address bit at position k, most significant first.
  function automatic logic msb_first(logic [6:0] a, int k);
    return (a >> (6 - k)) & 7'd1;
  endfunction

  // R12: strobes before any start do nothing.
  task automatic t_pre_start();
    load_own(7'h00);
    for (int i = 0; i < 10; i++) send_bit(1'b0);
    chk_all("R12", 0, 0, 0, 0);
  endtask

  // R4 R6 R7 R8 R10: fully matching frame.
  task automatic t_match(logic [6:0] a, logic dir);
    load_own(a);
    do_start();
    chk_all("R3", 0, 0, 0, 0);
    for (int k = 0; k < 7; k++) begin
      send_bit(msb_first(a, k));
      chk_all("R4", 0, 0, 0, 0);
    end
    rise(dir);
    chk("R6", "rw_flag", rw_flag, dir);
    chk("R7", "ack_drive before fall", ack_drive, 1'b0);
    idle(2);
    chk_all("R10", 0, 0, dir, 0);
    fall();
    chk("R7", "ack_drive open", ack_drive, 1'b1);
    chk("R8", "match_ok during ack", match_ok, 1'b0);
    rise(1'b0);
    chk_all("R7", 0, 0, dir, 1);
    fall();
    chk_all("R8", 1, 0, dir, 0);
    send_bit(~dir);
    send_bit(1'b0);
    chk_all("R10", 1, 0, dir, 0);
  endtask

  // R5 R9: mismatch at position bad_k, then the rest of the frame.
  task automatic t_mismatch(logic [6:0] own, logic [6:0] sent, int bad_k);
    load_own(own);
    do_start();
    for (int k = 0; k < 7; k++) begin
      rise(msb_first(sent, k));
      chk("R5", "match_bad after sample", match_bad, (k >= bad_k) ? 1'b1 : 1'b0);
      idle(1);
      fall();
    end
    rise(1'b1);
    chk_all("R9", 0, 1, 0, 0);
    fall();
    chk_all("R9", 0, 1, 0, 0);
    send_bit(1'b0);
    chk_all("R5", 0, 1, 0, 0);
  endtask

  // R3: new start after a failed frame clears fail; then a match succeeds.
  task automatic t_recover();
    t_mismatch(7'h73, 7'h63, 2);
    do_start();
    chk_all("R3", 0, 0, 0, 0);
    for (int k = 0; k < 7; k++) send_bit(msb_first(7'h73, k));
    send_bit(1'b1);
    chk("R7", "ack_drive after recover", ack_drive, 1'b1);
    send_bit(1'b0);
    chk_all("R3", 1, 0, 1, 0);
  endtask

  // R11: start partway through a frame restarts at the MSB.
  task automatic t_restart();
    load_own(7'h2A);
    do_start();
    for (int k = 0; k < 4; k++) send_bit(msb_first(7'h2A, k));
    do_start();
    for (int k = 0; k < 7; k++) send_bit(msb_first(7'h2A, k));
    send_bit(1'b0);
    send_bit(1'b0);
    chk_all("R11", 1, 0, 0, 0);
    // Fail on first bit, then restart mid-frame: must clear and match.
    do_start();
    send_bit(1'b1);
    chk("R11", "match_bad early", match_bad, 1'b1);
    do_start();
    chk("R11", "match_bad cleared", match_bad, 1'b0);
    for (int k = 0; k < 7; k++) send_bit(msb_first(7'h2A, k));
    send_bit(1'b1);
    send_bit(1'b0);
    chk_all("R11", 1, 0, 1, 0);
  endtask

  // R3: start with a coincident strobe - start wins.
  task automatic t_start_priority();
    load_own(7'h40);
    @(negedge clk); start_pulse = 1'b1; scl_rise = 1'b1; sda_in = 1'b0;
    @(negedge clk); start_pulse = 1'b0; scl_rise = 1'b0;
    chk("R3", "strobe with start ignored", match_bad, 1'b0);
    for (int k = 0; k < 7; k++) send_bit(msb_first(7'h40, k));
    send_bit(1'b0);
    send_bit(1'b0);
    chk_all("R3", 1, 0, 0, 0);
  endtask

  // R2: address held once load is low.
  task automatic t_load_hold();
    load_own(7'h55);
    @(negedge clk); own_addr_in = 7'h2B;
    do_start();
    for (int k = 0; k < 7; k++) send_bit(msb_first(7'h55, k));
    send_bit(1'b1);
    send_bit(1'b0);
    chk_all("R2", 1, 0, 1, 0);
    do_start();
    for (int k = 0; k < 7; k++) send_bit(msb_first(7'h2B, k));
    send_bit(1'b0);
    chk("R2", "new input not matched", match_bad, 1'b1);
  endtask

  initial begin
    idle(2);
    chk_all("R1", 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    chk_all("R1", 0, 0, 0, 0);
    t_pre_start();
    t_match(7'h63, 1'b0);
    t_match(7'h63, 1'b1);
    t_match(7'h7F, 1'b1);
    t_mismatch(7'h73, 7'h63, 2);
    t_mismatch(7'h01, 7'h00, 6);
    t_mismatch(7'h00, 7'h40, 0);
    t_recover();
    t_restart();
    t_start_priority();
    t_load_hold();
    idle(3);
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule